// File: doc/BRIEF.md
# Segment Table Address Translator

The translator turns a logical address into a physical one, using a small table of segments loaded for one process. A logical address is a segment number and an offset. The segment number picks one table entry, which holds a physical base, a limit giving the segment size in offset units, three permission bits and a valid bit. The offset is checked against the limit and the access kind is checked against the permissions. Only if both checks pass is the offset added to the base.

Configuration uses a write port that loads one whole entry per cycle. Translation requests arrive on a valid/ready port with a segment number, an offset and an access kind: read, write or instruction fetch. Each accepted request produces one registered response on a second valid/ready port, one cycle later. A response carries either a physical address or a two-bit fault code that names the kind of violation. A faulting response never carries an address.

Top module: `seg_xlate`

## Requirements
- R1: After reset `rsp_valid` is low and every table entry is marked not valid, so a request to any segment returns fault code 3.
- R2: A cycle with `cfg_we` high replaces entry `cfg_idx` with `cfg_base`, `cfg_limit`, `cfg_perm` and `cfg_valid`. The permission bits are bit 0 for read, bit 1 for write and bit 2 for execute.
- R3: For a valid entry with offset below the limit and a permitted access, the response has fault code 0 and address (base + offset) modulo 2^PA_W, with the offset zero-extended.
- R4: An offset equal to or above the entry's limit gives fault code 1 (bound) and address 0. A limit of 0 makes every offset a bound fault.
- R5: Access code 0 (read) needs permission bit 0, code 1 (write) needs bit 1, and code 2 (fetch) needs bit 2. Code 3 is never permitted. A refused access gives fault code 2 (permission) and address 0.
- R6: A request to an entry whose valid bit is clear gives fault code 3 and address 0, whatever its limit and permissions hold.
- R7: When checks fail together, the reported fault follows this order: invalid entry (3) first, then bound (1), then permission (2).
- R8: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Its response is presented with `rsp_valid` high from that edge on.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response holds stable and `req_ready` is low.
- R10: If a request is accepted in the same cycle as a table write to the entry it selects, the request is translated with the entry's old contents. The new contents apply from the next request on.
- R11: With `rsp_ready` high, one request is accepted every cycle. `rsp_valid` falls after a response is taken if no new request was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | $clog2(SEG_COUNT) | Entry to write |
| cfg_base | input | PA_W | Physical base of the segment |
| cfg_limit | input | OFF_W | Segment size in offset units |
| cfg_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| cfg_valid | input | 1 | Valid bit for the entry |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request can be accepted |
| req_seg | input | $clog2(SEG_COUNT) | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | PA_W | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 bound, 2 permission, 3 invalid entry |

## Verification
The bench probes an offset exactly equal to the limit, a limit of zero and an offset one below the limit. A design that used a less-or-equal compare would hand out an address one word past the segment. Requests that break several rules at once, including an invalid entry holding stale permissions, check the fault order. A wrong priority shows up as the wrong fault code. Base-plus-offset sums that run past the top of the physical space check that the address wraps rather than being clipped. A request issued in the same cycle as a write to its own entry checks R10: a bypass of the incoming write into the lookup would return the new base too early. Long stalls with requests waiting check R9: a design that dropped or overwrote a held response would lose a translation or change the address while the consumer is stalled.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    // Access kind carried with each request
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // Fault code returned with each response
    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_BOUND   = 2'd1,
        FLT_PERM    = 2'd2,
        FLT_INVALID = 2'd3
    } flt_e;

    // Bit positions inside the three permission bits
    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 2;
    localparam int PERM_W  = 3;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int SEG_COUNT = 8,
    parameter int OFF_W     = 16,
    parameter int PA_W      = 24,
    localparam int IDX_W    = $clog2(SEG_COUNT),
    localparam int PERM_W   = seg_xlate_pkg::PERM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PA_W-1:0]   wr_base,
    input  logic [OFF_W-1:0]  wr_limit,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic              wr_valid,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [PA_W-1:0]   rd_base,
    output logic [OFF_W-1:0]  rd_limit,
    output logic [PERM_W-1:0] rd_perm,
    output logic              rd_valid
);

    typedef struct packed {
        logic              valid;
        logic [PERM_W-1:0] perm;
        logic [OFF_W-1:0]  limit;
        logic [PA_W-1:0]   base;
    } entry_t;

    entry_t entries [SEG_COUNT];

    for (genvar i = 0; i < SEG_COUNT; i++) begin : g_entry
        entry_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                ent_d.valid = wr_valid;
                ent_d.perm  = wr_perm;
                ent_d.limit = wr_limit;
                ent_d.base  = wr_base;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign entries[i] = ent_q;
    end

    // Lookup reads registered state only, so a write in this cycle is unseen
    entry_t sel;
    always_comb begin
        sel = entries[rd_idx];
        rd_base  = sel.base;
        rd_limit = sel.limit;
        rd_perm  = sel.perm;
        rd_valid = sel.valid;
    end

endmodule

// File: rtl/seg_check.sv
module seg_check #(
    parameter int OFF_W   = 16,
    parameter int PA_W    = 24,
    localparam int PERM_W = seg_xlate_pkg::PERM_W
) (
    input  logic [PA_W-1:0]   ent_base,
    input  logic [OFF_W-1:0]  ent_limit,
    input  logic [PERM_W-1:0] ent_perm,
    input  logic              ent_valid,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        acc,
    output logic [PA_W-1:0]   phys,
    output logic [1:0]        fault
);
    import seg_xlate_pkg::*;

    logic in_bound;
    logic allowed;
    flt_e code;

    always_comb begin
        in_bound = (off < ent_limit);

        unique case (acc_e'(acc))
            ACC_READ:  allowed = ent_perm[PERM_RD];
            ACC_WRITE: allowed = ent_perm[PERM_WR];
            ACC_FETCH: allowed = ent_perm[PERM_EX];
            default:   allowed = 1'b0;
        endcase

        if (!ent_valid) begin
            code = FLT_INVALID;
        end else if (!in_bound) begin
            code = FLT_BOUND;
        end else if (!allowed) begin
            code = FLT_PERM;
        end else begin
            code = FLT_NONE;
        end

        fault = code;
        phys  = (code == FLT_NONE) ? (ent_base + PA_W'(off)) : '0;
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
    parameter int SEG_COUNT = 8,
    parameter int OFF_W     = 16,
    parameter int PA_W      = 24,
    localparam int IDX_W    = $clog2(SEG_COUNT),
    localparam int PERM_W   = seg_xlate_pkg::PERM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [PA_W-1:0]   cfg_base,
    input  logic [OFF_W-1:0]  cfg_limit,
    input  logic [PERM_W-1:0] cfg_perm,
    input  logic              cfg_valid,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IDX_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PA_W-1:0]   rsp_addr,
    output logic [1:0]        rsp_fault
);

    logic [PA_W-1:0]   sel_base;
    logic [OFF_W-1:0]  sel_limit;
    logic [PERM_W-1:0] sel_perm;
    logic              sel_valid;
    logic [PA_W-1:0]   xl_phys;
    logic [1:0]        xl_fault;

    seg_table #(
        .SEG_COUNT (SEG_COUNT),
        .OFF_W     (OFF_W),
        .PA_W      (PA_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_base  (cfg_base),
        .wr_limit (cfg_limit),
        .wr_perm  (cfg_perm),
        .wr_valid (cfg_valid),
        .rd_idx   (req_seg),
        .rd_base  (sel_base),
        .rd_limit (sel_limit),
        .rd_perm  (sel_perm),
        .rd_valid (sel_valid)
    );

    seg_check #(
        .OFF_W (OFF_W),
        .PA_W  (PA_W)
    ) u_check (
        .ent_base  (sel_base),
        .ent_limit (sel_limit),
        .ent_perm  (sel_perm),
        .ent_valid (sel_valid),
        .off       (req_off),
        .acc       (req_acc),
        .phys      (xl_phys),
        .fault     (xl_fault)
    );

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] addr;
        logic [1:0]      fault;
    } rsp_t;

    rsp_t rsp_d, rsp_q;
    logic take;

    always_comb begin
        req_ready = !rsp_q.valid || rsp_ready;
        take      = req_valid && req_ready;
        rsp_d     = rsp_q;
        if (take) begin
            rsp_d.valid = 1'b1;
            rsp_d.addr  = xl_phys;
            rsp_d.fault = xl_fault;
        end else if (rsp_ready) begin
            rsp_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_addr  = rsp_q.addr;
    assign rsp_fault = rsp_q.fault;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int PA_W = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [PA_W-1:0] rsp_addr,
    input logic [1:0]      rsp_fault
);

    // R8: an accepted request always yields a response on the next cycle
    p_accept_gives_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R9: a stalled response is held unchanged
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_fault)));

    // R9: no request is taken while a response is stalled
    p_ready_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |-> !req_ready);

    // R11: without a new acceptance the response slot empties or stays empty
    p_drop_after_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!(req_valid && req_ready) && !(rsp_valid && !rsp_ready)) |=> !rsp_valid);

    // R5: a faulting response carries no address
    p_fault_zero_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_addr == '0));

endmodule

bind seg_xlate seg_xlate_chk #(.PA_W(PA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_addr  (rsp_addr),
    .rsp_fault (rsp_fault)
);

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;

    localparam int SEG_COUNT = 8;
    localparam int OFF_W     = 16;
    localparam int PA_W      = 24;
    localparam int IDX_W     = $clog2(SEG_COUNT);
    localparam int WDOG      = 50000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [IDX_W-1:0]  cfg_idx = '0;
    logic [PA_W-1:0]   cfg_base = '0;
    logic [OFF_W-1:0]  cfg_limit = '0;
    logic [2:0]        cfg_perm = '0;
    logic              cfg_valid = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [IDX_W-1:0]  req_seg = '0;
    logic [OFF_W-1:0]  req_off = '0;
    logic [1:0]        req_acc = '0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b1;
    logic [PA_W-1:0]   rsp_addr;
    logic [1:0]        rsp_fault;

    always #5 clk = ~clk;

    seg_xlate #(.SEG_COUNT(SEG_COUNT), .OFF_W(OFF_W), .PA_W(PA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_limit(cfg_limit), .cfg_perm(cfg_perm), .cfg_valid(cfg_valid),
        .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
        .req_off(req_off), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_addr(rsp_addr), .rsp_fault(rsp_fault)
    );

    // Reference model state
    int unsigned m_base  [SEG_COUNT];
    int unsigned m_limit [SEG_COUNT];
    int unsigned m_perm  [SEG_COUNT];
    bit          m_vld   [SEG_COUNT];
    bit          e_valid;
    int unsigned e_addr;
    int unsigned e_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input string tag, input string what, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic void ref_xlate(input int seg, input int unsigned off, input int acc,
                                      output int unsigned addr, output int unsigned flt);
        bit ok;
        case (acc)
            0: ok = m_perm[seg][0];
            1: ok = m_perm[seg][1];
            2: ok = m_perm[seg][2];
            default: ok = 1'b0;
        endcase
        addr = 0;
        if (!m_vld[seg])               flt = 3;
        else if (off >= m_limit[seg])  flt = 1;
        else if (!ok)                  flt = 2;
        else begin
            flt  = 0;
            addr = (m_base[seg] + off) % (1 << PA_W);
        end
    endfunction

    // One clock: check ready, advance model at the edge, compare at negedge
    task automatic step(input string tag);
        bit acc_ok;
        int unsigned na, nf;
        #1;
        chk(tag, "req_ready", req_ready, (!e_valid || rsp_ready));
        acc_ok = req_valid && (!e_valid || rsp_ready);
        ref_xlate(req_seg, req_off, req_acc, na, nf);
        @(posedge clk);
        if (acc_ok) begin
            e_valid = 1'b1; e_addr = na; e_fault = nf;
        end else if (rsp_ready) begin
            e_valid = 1'b0;
        end
        if (cfg_we) begin
            m_base[cfg_idx]  = cfg_base;
            m_limit[cfg_idx] = cfg_limit;
            m_perm[cfg_idx]  = cfg_perm;
            m_vld[cfg_idx]   = cfg_valid;
        end
        @(negedge clk);
        chk(tag, "rsp_valid", rsp_valid, e_valid);
        if (e_valid) begin
            chk(tag, "rsp_fault", rsp_fault, e_fault);
            chk(tag, "rsp_addr", rsp_addr, e_addr);
        end
    endtask

    task automatic set_cfg(input int idx, input int unsigned base, input int unsigned lim,
                           input int perm, input bit vld);
        cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_base = PA_W'(base);
        cfg_limit = OFF_W'(lim); cfg_perm = 3'(perm); cfg_valid = vld;
    endtask

    task automatic set_req(input int seg, input int unsigned off, input int acc);
        req_valid = 1'b1; req_seg = IDX_W'(seg); req_off = OFF_W'(off); req_acc = 2'(acc);
    endtask

    task automatic idle();
        cfg_we = 1'b0; req_valid = 1'b0;
    endtask

    task automatic wr(input int idx, input int unsigned base, input int unsigned lim,
                      input int perm, input bit vld);
        set_cfg(idx, base, lim, perm, vld); step("R2"); idle();
    endtask

    task automatic rq(input int seg, input int unsigned off, input int acc, input string tag);
        set_req(seg, off, acc); step(tag); idle(); step(tag);
    endtask

    initial begin
        for (int i = 0; i < SEG_COUNT; i++) begin
            m_base[i] = 0; m_limit[i] = 0; m_perm[i] = 0; m_vld[i] = 0;
        end
        e_valid = 0; e_addr = 0; e_fault = 0;
        repeat (3) @(negedge clk);
        chk("R1", "rsp_valid in reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "rsp_valid after reset", rsp_valid, 0);

        // R1 / R6: every entry starts invalid
        for (int s = 0; s < SEG_COUNT; s++) rq(s, 0, 0, "R1");

        // R2 / R3: translation through a written entry
        wr(1, 24'h100000, 16'h1000, 3, 1'b1);
        rq(1, 16'h0010, 0, "R3");
        rq(1, 16'h0FFF, 1, "R3");
        rq(1, 16'h1000, 0, "R4");
        rq(1, 16'hFFFF, 1, "R4");
        rq(1, 16'h0020, 2, "R5");
        rq(1, 16'h0020, 3, "R5");
        rq(1, 16'h1000, 2, "R7");

        // R3: wrap past the top of the physical space
        wr(7, 24'hFFFF00, 16'hFFFF, 7, 1'b1);
        rq(7, 16'h0200, 2, "R3");
        rq(7, 16'hFFFE, 0, "R3");
        rq(7, 16'h0001, 3, "R5");

        // R4: zero limit
        wr(3, 24'h000400, 16'h0000, 7, 1'b1);
        rq(3, 16'h0000, 0, "R4");

        // R6 / R7: invalid entry with stale fields beats bound and permission
        wr(2, 24'h123456, 16'h0010, 0, 1'b0);
        rq(2, 16'h0005, 0, "R6");
        rq(2, 16'h0100, 1, "R7");
        wr(4, 24'h200000, 16'h0100, 4, 1'b1);
        rq(4, 16'h0010, 0, "R5");
        rq(4, 16'h0010, 2, "R3");

        // R10: same-cycle write and request to one entry
        set_cfg(1, 24'h300000, 16'h1000, 3, 1'b1);
        set_req(1, 16'h0044, 0);
        step("R10");
        idle();
        rq(1, 16'h0044, 0, "R10");
        set_cfg(4, 24'h0, 16'h0, 0, 1'b0);
        set_req(4, 16'h0010, 2);
        step("R10");
        idle();
        rq(4, 16'h0010, 2, "R10");

        // R9: stall with a request waiting
        set_req(7, 16'h0033, 0);
        step("R8");
        rsp_ready = 1'b0;
        set_req(1, 16'h0055, 1);
        for (int k = 0; k < 4; k++) step("R9");
        rsp_ready = 1'b1;
        step("R9");
        idle();
        step("R11");
        step("R11");

        // R11: back-to-back stream with random backpressure and config traffic
        for (int n = 0; n < 600; n++) begin
            if ($urandom_range(0, 5) == 0)
                set_cfg($urandom_range(0, SEG_COUNT - 1), $urandom, $urandom_range(0, 16'hFFFF),
                        $urandom_range(0, 7), $urandom_range(0, 3) != 0);
            else
                cfg_we = 1'b0;
            if ($urandom_range(0, 3) != 0)
                set_req($urandom_range(0, SEG_COUNT - 1),
                        ($urandom_range(0, 1) != 0) ? $urandom_range(0, 16'hFFFF) : $urandom_range(0, 32),
                        $urandom_range(0, 3));
            else
                req_valid = 1'b0;
            rsp_ready = ($urandom_range(0, 3) != 0);
            step("R11");
        end
        idle();
        rsp_ready = 1'b1;
        step("R11");
        step("R11");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < WDOG; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule